// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 32-bit virtual address into a 32-bit physical address through a sixteen-entry segment table held in registers. The top bits of the virtual address pick a table entry. Each entry holds a relocation base, a size limit and a two-bit access-rights code. The unit compares the low offset bits against the size limit and the requested access against the rights. It then returns either the relocated address or an error flag. There are two error flags, one for out-of-range offsets and one for rights violations.

A request is presented with `req_valid`, the virtual address and a write flag. The registered response appears on the following cycle. A privileged configuration port writes whole entries and reads any entry back in the same cycle. Software can therefore save the table of the outgoing process and load the table of the incoming one on a context switch. After reset every entry denies all access, so every translation faults until software programs the table.

Top module: `seg_xlate_unit`

## Requirements
- R1: The segment number is `req_vaddr[31:28]` and the offset is `req_vaddr[27:0]`, zero-extended to 32 bits for relocation.
- R2: A legal request gives, on the clock edge after it is presented, `rsp_valid`=1, both error flags 0, and `rsp_paddr` = base + offset, taken modulo 2^32.
- R3: An offset strictly greater than the entry's size raises `rsp_bound_err`. In that case `rsp_valid`=0 and `rsp_paddr`=0. An offset equal to the size is in range.
- R4: The rights codes are 2'b00 no access, 2'b01 read-only, 2'b10 read-write, and 2'b11, which is treated as no access. A request of any kind to a no-access entry raises `rsp_prot_err`.
- R5: A read (`req_write`=0) to a read-only entry is permitted. A write (`req_write`=1) to a read-only entry raises `rsp_prot_err`.
- R6: The bounds and protection checks are independent. Both flags assert together when both checks fail.
- R7: In a cycle with `req_valid`=0, the next cycle shows `rsp_valid`, both error flags and `rsp_paddr` all at 0.
- R8: A configuration write (`cfg_wr`=1) replaces base, size and rights of entry `cfg_idx` at the clock edge. A request presented in the same cycle still uses the old contents. The `cfg_rd_*` outputs combinationally show entry `cfg_idx`.
- R9: After reset every entry has rights 2'b00, base 0 and size 0, and all response outputs are 0.
- R10: A configuration write changes only the addressed entry. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Registered: translation succeeded |
| rsp_paddr | output | 32 | Registered physical address, 0 unless valid |
| rsp_bound_err | output | 1 | Registered: offset beyond segment size |
| rsp_prot_err | output | 1 | Registered: access denied by rights |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Entry index for write and readback |
| cfg_base | input | 32 | Base to write |
| cfg_size | input | 28 | Size limit (largest legal offset) to write |
| cfg_rights | input | 2 | Rights code to write |
| cfg_rd_base | output | 32 | Base of entry `cfg_idx` |
| cfg_rd_size | output | 28 | Size of entry `cfg_idx` |
| cfg_rd_rights | output | 2 | Rights of entry `cfg_idx` |

## Verification
Several properties are checked by the assertions on every cycle. A valid response never carries an error flag, and an erroring response carries a zero address. An idle cycle gives a quiet response. A legal lookup always becomes a valid response, and a no-access entry always faults. A configuration write always lands in its addressed entry. Other behaviour only the directed scenarios can show: the exact relocated address and its wraparound, the inclusive size limit, the split between read and write on read-only entries, the old entry being used when a request and a write share a cycle, and other entries staying untouched.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Two-bit rights code stored per segment entry.
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RW   = 2'b10,
    ACC_RSVD = 2'b11
  } acc_t;

  // True when the rights code lets the access through.
  function automatic logic acc_allows(acc_t r, logic is_write);
    logic ok;
    case (r)
      ACC_RW:  ok = 1'b1;
      ACC_RO:  ok = !is_write;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int PA_W  = 32,
  parameter int OFF_W = 28,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W-1:0] cfg_size,
  input  acc_t             cfg_rights,
  input  logic [SEG_W-1:0] lk_idx,
  output logic [PA_W-1:0]  lk_base,
  output logic [OFF_W-1:0] lk_size,
  output acc_t             lk_rights,
  output logic [PA_W-1:0]  rd_base,
  output logic [OFF_W-1:0] rd_size,
  output acc_t             rd_rights
);

  logic [PA_W-1:0]  base_q   [NSEG];
  logic [OFF_W-1:0] size_q   [NSEG];
  acc_t             rights_q [NSEG];
  logic [PA_W-1:0]  base_d   [NSEG];
  logic [OFF_W-1:0] size_d   [NSEG];
  acc_t             rights_d [NSEG];

  // Next-state: only the addressed entry changes.
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      base_d[i]   = base_q[i];
      size_d[i]   = size_q[i];
      rights_d[i] = rights_q[i];
    end
    if (cfg_wr) begin
      base_d[cfg_idx]   = cfg_base;
      size_d[cfg_idx]   = cfg_size;
      rights_d[cfg_idx] = cfg_rights;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]   <= '0;
        size_q[i]   <= '0;
        rights_q[i] <= ACC_NONE;
      end
    end else if (cfg_wr) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]   <= base_d[i];
        size_q[i]   <= size_d[i];
        rights_q[i] <= rights_d[i];
      end
    end
  end

  // Translation lookup port.
  assign lk_base   = base_q[lk_idx];
  assign lk_size   = size_q[lk_idx];
  assign lk_rights = rights_q[lk_idx];

  // Save/restore readback port.
  assign rd_base   = base_q[cfg_idx];
  assign rd_size   = size_q[cfg_idx];
  assign rd_rights = rights_q[cfg_idx];

  // R8: a configuration write is visible in the addressed entry afterwards
  p_cfg_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (base_q[$past(cfg_idx)] == $past(cfg_base)) &&
               (size_q[$past(cfg_idx)] == $past(cfg_size)) &&
               (rights_q[$past(cfg_idx)] == $past(cfg_rights)));

  // R10: without a write, the looked-up entry's contents hold still
  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> (base_q[$past(lk_idx)] == $past(lk_base)) &&
                (rights_q[$past(lk_idx)] == $past(lk_rights)));

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 28
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  input  logic [PA_W-1:0]  base,
  input  logic [OFF_W-1:0] size,
  input  acc_t             rights,
  output logic             bound_err,
  output logic             prot_err,
  output logic [PA_W-1:0]  paddr
);

  logic [PA_W-1:0] off_ext;

  always_comb begin
    off_ext   = PA_W'(offset);
    bound_err = (offset > size);
    prot_err  = !acc_allows(rights, is_write);
    paddr     = base + off_ext;
  end

  // R4: a no-access entry never passes the rights check
  always_comb begin
    if (rights == ACC_NONE || rights == ACC_RSVD)
      a_none_denies_r4: assert (prot_err);
  end

endmodule

// File: rtl/seg_out_reg.sv
module seg_out_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            bound_err,
  input  logic            prot_err,
  input  logic [PA_W-1:0] paddr,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_bound_err,
  output logic            rsp_prot_err
);

  logic            valid_d, berr_d, perr_d;
  logic [PA_W-1:0] paddr_d;

  always_comb begin
    valid_d = req_valid && !bound_err && !prot_err;
    berr_d  = req_valid && bound_err;
    perr_d  = req_valid && prot_err;
    paddr_d = valid_d ? paddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_bound_err <= 1'b0;
      rsp_prot_err  <= 1'b0;
    end else begin
      rsp_valid     <= valid_d;
      rsp_paddr     <= paddr_d;
      rsp_bound_err <= berr_d;
      rsp_prot_err  <= perr_d;
    end
  end

  // R3: a successful response never carries an error flag
  p_valid_excl_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_bound_err && !rsp_prot_err);

  // R3: an erroring response exposes no address
  p_err_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_bound_err || rsp_prot_err) |-> (rsp_paddr == '0));

  // R7: an idle cycle yields a quiet response
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_bound_err && !rsp_prot_err && (rsp_paddr == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 4,
  parameter int PA_W  = 32,
  localparam int OFF_W = VA_W - SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_bound_err,
  output logic             rsp_prot_err,
  input  logic             cfg_wr,
  input  logic [SEG_W-1:0] cfg_idx,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [OFF_W-1:0] cfg_size,
  input  logic [1:0]       cfg_rights,
  output logic [PA_W-1:0]  cfg_rd_base,
  output logic [OFF_W-1:0] cfg_rd_size,
  output logic [1:0]       cfg_rd_rights
);

  logic [SEG_W-1:0] seg_num;
  logic [OFF_W-1:0] seg_off;
  logic [PA_W-1:0]  lk_base;
  logic [OFF_W-1:0] lk_size;
  acc_t             lk_rights;
  acc_t             rd_rights;
  logic             chk_berr, chk_perr;
  logic [PA_W-1:0]  chk_paddr;

  // R1: high field selects the entry, low field is the offset
  assign seg_num = req_vaddr[VA_W-1:OFF_W];
  assign seg_off = req_vaddr[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_idx    (cfg_idx),
    .cfg_base   (cfg_base),
    .cfg_size   (cfg_size),
    .cfg_rights (acc_t'(cfg_rights)),
    .lk_idx     (seg_num),
    .lk_base    (lk_base),
    .lk_size    (lk_size),
    .lk_rights  (lk_rights),
    .rd_base    (cfg_rd_base),
    .rd_size    (cfg_rd_size),
    .rd_rights  (rd_rights)
  );

  assign cfg_rd_rights = rd_rights;

  seg_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .offset    (seg_off),
    .is_write  (req_write),
    .base      (lk_base),
    .size      (lk_size),
    .rights    (lk_rights),
    .bound_err (chk_berr),
    .prot_err  (chk_perr),
    .paddr     (chk_paddr)
  );

  seg_out_reg #(.PA_W(PA_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .bound_err     (chk_berr),
    .prot_err      (chk_perr),
    .paddr         (chk_paddr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_bound_err (rsp_bound_err),
    .rsp_prot_err  (rsp_prot_err)
  );

  // R2: a request passing both checks becomes a valid response with its address
  p_legal_gives_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !chk_berr && !chk_perr) |=> rsp_valid && (rsp_paddr == $past(chk_paddr)));

  // R4: a request to a no-access entry always reports a protection error
  p_none_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (lk_rights == ACC_NONE || lk_rights == ACC_RSVD)) |=> rsp_prot_err);

  // R6: an out-of-range request always reports a bounds error, whatever its rights
  p_bound_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (seg_off > lk_size)) |=> rsp_bound_err);

endmodule

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_bound_err;
  logic        rsp_prot_err;
  logic        cfg_wr;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_base;
  logic [27:0] cfg_size;
  logic [1:0]  cfg_rights;
  logic [31:0] cfg_rd_base;
  logic [27:0] cfg_rd_size;
  logic [1:0]  cfg_rd_rights;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench-side model of the table.
  logic [31:0] m_base   [16];
  logic [27:0] m_size   [16];
  logic [1:0]  m_rights [16];

  always #5 clk = ~clk;

  seg_xlate_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_bound_err(rsp_bound_err), .rsp_prot_err(rsp_prot_err),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_rights(cfg_rights),
    .cfg_rd_base(cfg_rd_base), .cfg_rd_size(cfg_rd_size), .cfg_rd_rights(cfg_rd_rights)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [3:0] idx, logic [31:0] b, logic [27:0] s, logic [1:0] r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_base = b; cfg_size = s; cfg_rights = r;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_base[idx] = b; m_size[idx] = s; m_rights[idx] = r;
  endtask

  // Expected response from the requirements.
  task automatic expect_rsp(logic [3:0] seg, logic [27:0] off, logic wr,
                            output logic v, output logic [31:0] pa,
                            output logic be, output logic pe);
    logic [1:0] r;
    r  = m_rights[seg];
    be = (off > m_size[seg]);
    pe = (r == 2'b00) || (r == 2'b11) || (r == 2'b01 && wr);
    v  = !be && !pe;
    pa = v ? (m_base[seg] + {4'h0, off}) : 32'h0;
  endtask

  // Presents one request and checks the registered response one edge later.
  task automatic xlate(string req, logic [3:0] seg, logic [27:0] off, logic wr);
    logic v, be, pe;
    logic [31:0] pa;
    expect_rsp(seg, off, wr, v, pa, be, pe);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {seg, off}; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "rsp_valid", rsp_valid, v);
    chk(req, "rsp_paddr", rsp_paddr, pa);
    chk(req, "rsp_bound_err", rsp_bound_err, be);
    chk(req, "rsp_prot_err", rsp_prot_err, pe);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_idx = i[3:0];
      #1;
      chk("R9", "reset rights", cfg_rd_rights, 2'b00);
      chk("R9", "reset base", cfg_rd_base, 32'h0);
      chk("R9", "reset size", cfg_rd_size, 28'h0);
    end
    chk("R9", "reset rsp_valid", rsp_valid, 1'b0);
    chk("R9", "reset rsp_paddr", rsp_paddr, 32'h0);
    xlate("R9", 4'h3, 28'h0, 1'b0);
  endtask

  task automatic t_program;
    cfg_write(4'h1, 32'h1000_0000, 28'h000_0FFF, 2'b10);
    cfg_write(4'h2, 32'h2000_4000, 28'h000_00FF, 2'b01);
    cfg_write(4'h5, 32'h0000_0000, 28'h000_0010, 2'b00);
    cfg_write(4'h6, 32'h4000_0000, 28'h000_0100, 2'b11);
    cfg_write(4'hF, 32'hFFFF_F000, 28'hFFF_FFFF, 2'b10);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfg_idx = i[3:0];
      #1;
      chk("R10", "readback base", cfg_rd_base, m_base[i]);
      chk("R8", "readback size", cfg_rd_size, m_size[i]);
      chk("R8", "readback rights", cfg_rd_rights, m_rights[i]);
    end
  endtask

  task automatic t_legal;
    xlate("R2", 4'h1, 28'h000_0123, 1'b0);
    xlate("R2", 4'h1, 28'h000_0ABC, 1'b1);
    xlate("R1", 4'hF, 28'h000_0010, 1'b0);
  endtask

  task automatic t_wrap;
    xlate("R2", 4'hF, 28'h000_2345, 1'b1);
  endtask

  task automatic t_bounds;
    xlate("R3", 4'h1, 28'h000_0FFF, 1'b0);
    xlate("R3", 4'h1, 28'h000_1000, 1'b0);
    xlate("R3", 4'h1, 28'hFFF_FFFF, 1'b1);
  endtask

  task automatic t_ro;
    xlate("R5", 4'h2, 28'h000_0040, 1'b0);
    xlate("R5", 4'h2, 28'h000_0040, 1'b1);
  endtask

  task automatic t_none;
    xlate("R4", 4'h5, 28'h000_0001, 1'b0);
    xlate("R4", 4'h6, 28'h000_0001, 1'b0);
    xlate("R4", 4'h6, 28'h000_0001, 1'b1);
  endtask

  task automatic t_both;
    xlate("R6", 4'h5, 28'h000_0020, 1'b1);
    xlate("R6", 4'h2, 28'h000_0100, 1'b1);
  endtask

  task automatic t_idle;
    xlate("R7", 4'h1, 28'h000_0004, 1'b0);
    @(negedge clk);
    chk("R7", "idle rsp_valid", rsp_valid, 1'b0);
    chk("R7", "idle rsp_paddr", rsp_paddr, 32'h0);
    xlate("R7", 4'h5, 28'h0, 1'b0);
    @(negedge clk);
    chk("R7", "idle rsp_prot_err", rsp_prot_err, 1'b0);
  endtask

  // Request and write in the same cycle: the request uses the old entry.
  task automatic t_same_cycle;
    logic v, be, pe;
    logic [31:0] pa;
    expect_rsp(4'h1, 28'h000_0200, 1'b0, v, pa, be, pe);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {4'h1, 28'h000_0200}; req_write = 1'b0;
    cfg_wr = 1'b1; cfg_idx = 4'h1; cfg_base = 32'h3000_0000;
    cfg_size = 28'h000_0010; cfg_rights = 2'b00;
    @(negedge clk);
    req_valid = 1'b0; cfg_wr = 1'b0;
    m_base[1] = 32'h3000_0000; m_size[1] = 28'h000_0010; m_rights[1] = 2'b00;
    chk("R8", "same-cycle rsp_valid", rsp_valid, v);
    chk("R8", "same-cycle rsp_paddr", rsp_paddr, pa);
    xlate("R8", 4'h1, 28'h000_0200, 1'b0);
    cfg_write(4'h1, 32'h3000_0000, 28'h000_0FFF, 2'b10);
    xlate("R8", 4'h1, 28'h000_0200, 1'b1);
    cfg_idx = 4'h2;
    #1;
    chk("R10", "neighbour base kept", cfg_rd_base, 32'h2000_4000);
    xlate("R10", 4'h2, 28'h000_0010, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_rights[i] = 2'b00;
    end
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    cfg_wr = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_size = '0; cfg_rights = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_program;
    t_legal;
    t_wrap;
    t_bounds;
    t_ro;
    t_none;
    t_both;
    t_idle;
    t_same_cycle;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule